// File: doc/BRIEF.md
# Thermal Throttle Controller with Hysteresis

This block turns a die temperature sensor into frequency requests. A 32-bit calibration word gives two calibration points. One is the sensor count at room temperature (25 °C). The other is the count and temperature at a hot point. From these two points the block works out two raw sensor counts. The trigger count matches the throttle temperature. The release count matches a lower temperature and supplies the hysteresis. The sensor runs inverted: a lower count means a hotter die.

Each threshold is computed by a small sequential multiply and restoring divide engine. The engine runs after every calibration load and after every change of the throttle temperature. A ready flag stays low while the engine works, and no request is made during that time. The block keeps the most recent valid sensor count. On every check tick (typically 10 Hz) it requests the minimum frequency when the die is above the trigger temperature. It requests the maximum frequency when the die has cooled past the release temperature. A request is suppressed when the frequency sequencer already reports that limit.

Top module: `thermal_throttle`

## Requirements
- R1: The calibration word is decoded as room count = bits 31:20, hot count = bits 19:8, and hot temperature = bits 7:0 in whole °C, multiplied by 10 to give deci-°C (hv).
- R2: A temperature T in deci-°C maps to count = floor((room − hot) × (hv − T) / (hv − 250)) + hot. The term (room − hot) is taken as 0 when room ≤ hot. The term (hv − T) is taken as 0 when T ≥ hv. The result saturates at 4095. When hv ≤ 250 the count is the hot count.
- R3: After a calibration load, trig_cnt is the count for hv − 100 and rel_cnt is the count for hv − 150. A temperature below 0 is clamped to 0.
- R4: A throttle load while ready is high sets trig_cnt to the count for thr_temp and rel_cnt to the count for thr_temp − 100, clamped at 0. A throttle load while ready is low is ignored.
- R5: ready is low in the cycle after a calibration load and returns high within 100 cycles. A new calibration load restarts the computation.
- R6: A sensor count is captured only in a cycle with sample_valid high. Counts presented with sample_valid low have no effect on later requests.
- R7: No request is made until a valid nonzero count has been captured, or while ready is low.
- R8: One cycle after a tick, go_slow pulses when the captured count is below trig_cnt and at_min is low.
- R9: One cycle after a tick, go_fast pulses when the captured count is not below trig_cnt, is above rel_cnt, and at_max is low.
- R10: Counts from trig_cnt to rel_cnt inclusive produce no request. No request appears without a tick, and go_slow and go_fast are never high together.
- R11: After reset, ready, go_slow, go_fast, trig_cnt and rel_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_load | input | 1 | Latch cal_word and recompute thresholds |
| cal_word | input | 32 | Two-point calibration word |
| thr_load | input | 1 | Latch thr_temp as new throttle temperature |
| thr_temp | input | TEMP_W | Throttle temperature, deci-°C |
| sample_valid | input | 1 | Sensor count is valid this cycle |
| sample_cnt | input | CNT_W | Raw sensor count (lower = hotter) |
| tick | input | 1 | Periodic throttle check strobe |
| at_min | input | 1 | Frequency already at minimum |
| at_max | input | 1 | Frequency already at maximum |
| go_slow | output | 1 | Request minimum frequency (pulse) |
| go_fast | output | 1 | Request maximum frequency (pulse) |
| ready | output | 1 | Thresholds valid, comparisons enabled |
| trig_cnt | output | CNT_W | Trigger threshold count |
| rel_cnt | output | CNT_W | Release threshold count |

## Verification
The threshold arithmetic is swept over a grid of calibration words. The grid covers normal, inverted and degenerate cases (room count below the hot count, hot temperature at or below 25 °C), and each point is combined with several programmed throttle temperatures, so that clamping, saturation and floor division can each be told apart from the plain formula. The comparator is driven with every count from just below the trigger count to just above the release count, under all four combinations of the limit flags. This separates strict from inclusive comparisons and shows the suppression by each flag. Directed sequences cover arming by a first nonzero sample, invalid samples, ticks while busy, and throttle loads while busy.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int CNT_W       = 12;
  localparam int TEMP_W      = 12;
  localparam int ROOM_LSB    = 20;
  localparam int HOT_LSB     = 8;
  localparam int HOTC_W      = 8;
  localparam int ROOM_DC     = 250;  // 25.0 C in deci-C
  localparam int TRIG_BACK   = 100;  // throttle point below hot cal temperature
  localparam int REL_GAP_CAL = 50;   // release gap after a calibration load
  localparam int REL_GAP_PRG = 100;  // release gap after a throttle load

  typedef enum logic [2:0] {
    E_IDLE, E_TRIG_GO, E_TRIG_WAIT, E_REL_GO, E_REL_WAIT
  } eng_st_t;

  typedef enum logic [1:0] {
    M_IDLE, M_MUL, M_DIV, M_DONE
  } md_st_t;
endpackage

// File: rtl/thr_muldiv.sv
module thr_muldiv
  import thr_pkg::*;
#(
  parameter int AW = 12,
  parameter int BW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic [BW-1:0]    d,
  output logic             done,
  output logic [AW+BW-1:0] q
);
  localparam int PW  = AW + BW;
  localparam int CTW = $clog2(PW + 1);

  md_st_t         st;
  logic [CTW-1:0] cnt;
  logic [PW-1:0]  acc, mc, dvd, quo;
  logic [BW-1:0]  mp, dv;
  logic [BW:0]    rem;

  logic [PW-1:0]  acc_nx;
  logic [BW:0]    rem_sh;
  logic           fits;

  always_comb begin
    acc_nx = mp[0] ? acc + mc : acc;
    rem_sh = {rem[BW-1:0], dvd[PW-1]};
    fits   = rem_sh >= {1'b0, dv};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= M_IDLE;
      cnt <= '0;
      acc <= '0;
      mc  <= '0;
      mp  <= '0;
      dv  <= '0;
      dvd <= '0;
      quo <= '0;
      rem <= '0;
    end else if (start) begin
      st  <= M_MUL;
      cnt <= '0;
      acc <= '0;
      mc  <= PW'(a);
      mp  <= b;
      dv  <= d;
      rem <= '0;
      quo <= '0;
    end else begin
      case (st)
        M_MUL: begin
          acc <= acc_nx;
          mc  <= mc << 1;
          mp  <= mp >> 1;
          if (cnt == CTW'(BW - 1)) begin
            st  <= M_DIV;
            cnt <= '0;
            dvd <= acc_nx;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_DIV: begin
          dvd <= dvd << 1;
          if (fits) begin
            rem <= rem_sh - {1'b0, dv};
            quo <= {quo[PW-2:0], 1'b1};
          end else begin
            rem <= rem_sh;
            quo <= {quo[PW-2:0], 1'b0};
          end
          if (cnt == CTW'(PW - 1)) st <= M_DONE;
          else                     cnt <= cnt + 1'b1;
        end
        M_DONE:  st <= M_IDLE;
        default: st <= M_IDLE;
      endcase
    end
  end

  assign done = (st == M_DONE);
  assign q    = quo;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_DIV && dv != '0) |-> (rem < {1'b0, dv})); // R2
endmodule

// File: rtl/thr_cal_engine.sv
module thr_cal_engine
  import thr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int TW = TEMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_load,
  input  logic [31:0]   cal_word,
  input  logic          thr_load,
  input  logic [TW-1:0] thr_temp,
  output logic          ready,
  output logic [CW-1:0] trig_cnt,
  output logic [CW-1:0] rel_cnt
);
  localparam int PW = CW + TW;
  localparam int SW = PW + 1;

  function automatic logic [TW-1:0] floor_sub(logic [TW-1:0] x, logic [TW-1:0] y);
    return (x > y) ? x - y : '0;
  endfunction

  function automatic logic [CW-1:0] to_count(logic [PW-1:0] quot, logic [CW-1:0] base);
    logic [SW-1:0] s;
    s = {1'b0, quot} + SW'(base);
    return (s > SW'({CW{1'b1}})) ? '1 : s[CW-1:0];
  endfunction

  eng_st_t       st;
  logic          cal_valid;
  logic [CW-1:0] room, hot;
  logic [TW-1:0] hot_val, trig_t, rel_t;

  logic [TW-1:0] hv_dec, cur_t;
  logic          md_start, md_done, degenerate;
  logic [CW-1:0] md_a, result;
  logic [TW-1:0] md_b, md_d;
  logic [PW-1:0] md_q;

  always_comb begin
    hv_dec     = TW'(cal_word[HOTC_W-1:0]) * TW'(10);
    cur_t      = (st == E_TRIG_GO || st == E_TRIG_WAIT) ? trig_t : rel_t;
    md_start   = (st == E_TRIG_GO) || (st == E_REL_GO);
    md_a       = (room > hot) ? room - hot : '0;
    md_b       = floor_sub(hot_val, cur_t);
    md_d       = floor_sub(hot_val, TW'(ROOM_DC));
    degenerate = (hot_val <= TW'(ROOM_DC));
    result     = degenerate ? hot : to_count(md_q, hot);
  end

  thr_muldiv #(.AW(CW), .BW(TW)) u_md (
    .clk(clk), .rst_n(rst_n), .start(md_start),
    .a(md_a), .b(md_b), .d(md_d), .done(md_done), .q(md_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cal_valid <= 1'b0;
      room      <= '0;
      hot       <= '0;
      hot_val   <= '0;
      trig_t    <= '0;
      rel_t     <= '0;
      trig_cnt  <= '0;
      rel_cnt   <= '0;
    end else if (cal_load) begin
      room      <= cal_word[ROOM_LSB +: CW];
      hot       <= cal_word[HOT_LSB +: CW];
      hot_val   <= hv_dec;
      trig_t    <= floor_sub(hv_dec, TW'(TRIG_BACK));
      rel_t     <= floor_sub(hv_dec, TW'(TRIG_BACK + REL_GAP_CAL));
      cal_valid <= 1'b1;
      st        <= E_TRIG_GO;
    end else begin
      case (st)
        E_IDLE: if (thr_load && cal_valid) begin
          trig_t <= thr_temp;
          rel_t  <= floor_sub(thr_temp, TW'(REL_GAP_PRG));
          st     <= E_TRIG_GO;
        end
        E_TRIG_GO:   st <= E_TRIG_WAIT;
        E_TRIG_WAIT: if (md_done) begin
          trig_cnt <= result;
          st       <= E_REL_GO;
        end
        E_REL_GO:    st <= E_REL_WAIT;
        E_REL_WAIT:  if (md_done) begin
          rel_cnt <= result;
          st      <= E_IDLE;
        end
        default:     st <= E_IDLE;
      endcase
    end
  end

  assign ready = cal_valid && (st == E_IDLE);

  AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_load |=> !ready); // R5
  AST_BUSY_THR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_load && !ready && !cal_load) |=> $stable(trig_t)); // R4
  AST_HYST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (rel_cnt >= trig_cnt)); // R3
endmodule

// File: rtl/thr_decide.sv
module thr_decide #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic [CW-1:0] trig_cnt,
  input  logic [CW-1:0] rel_cnt,
  input  logic          sample_valid,
  input  logic [CW-1:0] sample_cnt,
  input  logic          tick,
  input  logic          at_min,
  input  logic          at_max,
  output logic          go_slow,
  output logic          go_fast
);
  logic [CW-1:0] last;
  logic          armed;
  logic          check_en, is_hot, is_cool;

  assign check_en = tick && ready && armed;
  assign is_hot   = last < trig_cnt;
  assign is_cool  = last > rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last    <= '0;
      armed   <= 1'b0;
      go_slow <= 1'b0;
      go_fast <= 1'b0;
    end else begin
      if (sample_valid) begin
        last <= sample_cnt;
        if (sample_cnt != '0) armed <= 1'b1;
      end
      go_slow <= check_en && is_hot && !at_min;
      go_fast <= check_en && !is_hot && is_cool && !at_max;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_slow && go_fast)); // R10
  AST_REQ_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (go_slow || go_fast) |-> $past(tick && ready && armed)); // R7
  AST_NO_SLOW_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    go_slow |-> !$past(at_min)); // R8
  AST_NO_FAST_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    go_fast |-> !$past(at_max)); // R9
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(last)); // R6
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
#(
  parameter int CNT_W  = thr_pkg::CNT_W,
  parameter int TEMP_W = thr_pkg::TEMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_load,
  input  logic [31:0]       cal_word,
  input  logic              thr_load,
  input  logic [TEMP_W-1:0] thr_temp,
  input  logic              sample_valid,
  input  logic [CNT_W-1:0]  sample_cnt,
  input  logic              tick,
  input  logic              at_min,
  input  logic              at_max,
  output logic              go_slow,
  output logic              go_fast,
  output logic              ready,
  output logic [CNT_W-1:0]  trig_cnt,
  output logic [CNT_W-1:0]  rel_cnt
);
  thr_cal_engine #(.CW(CNT_W), .TW(TEMP_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_word(cal_word),
    .thr_load(thr_load), .thr_temp(thr_temp), .ready(ready),
    .trig_cnt(trig_cnt), .rel_cnt(rel_cnt)
  );

  thr_decide #(.CW(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ready(ready), .trig_cnt(trig_cnt),
    .rel_cnt(rel_cnt), .sample_valid(sample_valid), .sample_cnt(sample_cnt),
    .tick(tick), .at_min(at_min), .at_max(at_max),
    .go_slow(go_slow), .go_fast(go_fast)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !(go_slow || go_fast)); // R11
endmodule

// File: tb/tb_thermal_throttle.sv
module tb_thermal_throttle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_load = 1'b0, thr_load = 1'b0, sample_valid = 1'b0;
  logic        tick = 1'b0, at_min = 1'b0, at_max = 1'b0;
  logic [31:0] cal_word = '0;
  logic [11:0] thr_temp = '0, sample_cnt = '0;
  logic        go_slow, go_fast, ready;
  logic [11:0] trig_cnt, rel_cnt;

  int n_chk = 0, n_fail = 0;
  int c_room, c_hot, c_hv;

  always #10 clk = ~clk;

  thermal_throttle dut (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_word(cal_word),
    .thr_load(thr_load), .thr_temp(thr_temp), .sample_valid(sample_valid),
    .sample_cnt(sample_cnt), .tick(tick), .at_min(at_min), .at_max(at_max),
    .go_slow(go_slow), .go_fast(go_fast), .ready(ready),
    .trig_cnt(trig_cnt), .rel_cnt(rel_cnt)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // two-point linear map, restated with plain integer arithmetic
  function automatic int ref_cnt(int room, int hot, int hv, int t);
    int a, b, s;
    if (hv <= 250) return hot;
    a = (room > hot) ? room - hot : 0;
    b = (t >= hv) ? 0 : hv - t;
    s = (a * b) / (hv - 250) + hot;
    return (s > 4095) ? 4095 : s;
  endfunction

  function automatic int clamp0(int v);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic wait_ready(string req);
    int n = 0;
    while (!ready && n < 300) begin
      @(negedge clk);
      n++;
    end
    n_chk++;
    if (n > 100) begin
      n_fail++;
      $display("FAIL %s ready latency actual=%0d expected<=100", req, n);
    end
  endtask

  task automatic load_cal(int room, int hot, int hc);
    @(negedge clk);
    cal_word = {room[11:0], hot[11:0], hc[7:0]};
    cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    chk("R5 ready low after load", int'(ready), 0);
    c_room = room; c_hot = hot; c_hv = hc * 10;
    wait_ready("R5");
  endtask

  task automatic load_thr(int t);
    @(negedge clk);
    thr_temp = t[11:0];
    thr_load = 1'b1;
    @(negedge clk);
    thr_load = 1'b0;
    wait_ready("R5 after thr load");
  endtask

  task automatic send_sample(bit v, int c);
    @(negedge clk);
    sample_valid = v;
    sample_cnt = c[11:0];
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic do_tick(string req, bit es, bit ef);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk({req, " go_slow"}, int'(go_slow), int'(es));
    chk({req, " go_fast"}, int'(go_fast), int'(ef));
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
  end

  initial begin
    int hcs[8]   = '{20, 25, 26, 60, 90, 105, 125, 255};
    int rooms[3] = '{1440, 1024, 256};
    int hots[3]  = '{1184, 848, 512};
    int temps[5] = '{0, 250, 600, 1000, 3000};
    int tr, rl;

    repeat (3) @(negedge clk);
    chk("R11 ready", int'(ready), 0);
    chk("R11 go_slow", int'(go_slow), 0);
    chk("R11 go_fast", int'(go_fast), 0);
    chk("R11 trig_cnt", int'(trig_cnt), 0);
    chk("R11 rel_cnt", int'(rel_cnt), 0);
    rst_n = 1'b1;

    do_tick("R7 before calibration", 0, 0);

    // reference calibration: trig 1216, rel 1232
    load_cal(1440, 1184, 105);
    chk("R1 R3 trig", int'(trig_cnt), ref_cnt(1440, 1184, 1050, 950));
    chk("R1 R3 rel", int'(rel_cnt), ref_cnt(1440, 1184, 1050, 900));
    tr = ref_cnt(1440, 1184, 1050, 950);
    rl = ref_cnt(1440, 1184, 1050, 900);

    do_tick("R7 unarmed", 0, 0);
    send_sample(1'b1, 0);
    do_tick("R7 zero sample does not arm", 0, 0);
    send_sample(1'b1, tr + 3);
    do_tick("R10 between thresholds", 0, 0);
    send_sample(1'b0, 16);
    do_tick("R6 invalid sample ignored", 0, 0);
    send_sample(1'b1, 16);
    do_tick("R8 hot sample", 1, 0);
    repeat (3) @(negedge clk);
    chk("R10 no request without tick", int'(go_slow || go_fast), 0);

    // tick while busy
    @(negedge clk);
    cal_word = {12'd1440, 12'd1184, 8'd105};
    cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    do_tick("R7 not ready", 0, 0);
    wait_ready("R5");

    // throttle load while busy is ignored
    @(negedge clk);
    cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    thr_temp = 12'd500;
    thr_load = 1'b1;
    @(negedge clk);
    thr_load = 1'b0;
    wait_ready("R5");
    chk("R4 busy load ignored trig", int'(trig_cnt), tr);
    chk("R4 busy load ignored rel", int'(rel_cnt), rl);

    // restart of a running computation
    @(negedge clk);
    cal_word = {12'd1024, 12'd848, 8'd90};
    cal_load = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    repeat (20) @(negedge clk);
    load_cal(1440, 1184, 105);
    chk("R5 restart trig", int'(trig_cnt), tr);

    // comparator sweep across both thresholds and limit flags
    for (int c = tr - 4; c <= rl + 4; c++) begin
      for (int m = 0; m < 4; m++) begin
        bit es, ef;
        at_min = m[0];
        at_max = m[1];
        send_sample(1'b1, c);
        es = (c < tr) && !m[0];
        ef = !(c < tr) && (c > rl) && !m[1];
        do_tick(es ? "R8" : (ef ? "R9" : "R10"), es, ef);
      end
    end
    at_min = 1'b0;
    at_max = 1'b0;

    // arithmetic sweep over calibration and throttle temperatures
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        for (int k = 0; k < 8; k++) begin
          int hv;
          hv = hcs[k] * 10;
          load_cal(rooms[i], hots[j], hcs[k]);
          chk("R1 R2 R3 trig", int'(trig_cnt),
              ref_cnt(rooms[i], hots[j], hv, clamp0(hv - 100)));
          chk("R1 R2 R3 rel", int'(rel_cnt),
              ref_cnt(rooms[i], hots[j], hv, clamp0(hv - 150)));
          for (int t = 0; t < 5; t++) begin
            load_thr(temps[t]);
            chk("R2 R4 trig", int'(trig_cnt),
                ref_cnt(rooms[i], hots[j], hv, temps[t]));
            chk("R2 R4 rel", int'(rel_cnt),
                ref_cnt(rooms[i], hots[j], hv, clamp0(temps[t] - 100)));
          end
        end
      end
    end

    summary();
  end
endmodule